// File: doc/BRIEF.md
# Ethernet PAUSE Frame Detector

This block watches the byte stream delivered by a receive MAC and recognises MAC-control PAUSE frames. Every accepted byte is placed by its position in the frame. The destination address, the type and the opcode are compared against their required values as the bytes go by. The two bytes of the pause time are captured. The source address is skipped.

At the end-of-frame beat the block makes one decision. A frame qualifies only if all of the following hold: full-duplex mode is on, receive flow control is on, the MAC reports the frame good, all required fields matched, and the frame was long enough to carry the pause time. When a frame qualifies, the block raises a single-cycle pulse in the next cycle. In the same cycle it presents the captured 16-bit pause quanta, and it holds that value until the next detection. The pulse is meant to drive a transmit pause timer elsewhere in the MAC.

The block does not check the CRC. The receive MAC is trusted to fold the CRC result into its good status.

Top module: `pause_frame_detector`

## Requirements
- R1: A pulse is produced only when both `full_duplex_en_i` and `flow_ctrl_en_i` are 1 at the end-of-frame beat. If either is 0, the frame produces no pulse.
- R2: A destination address of 01-80-C2-00-00-01 is accepted. Its first received byte (frame byte 0) is 0x01.
- R3: A destination address equal to `station_addr_i` is accepted. Frame byte 0 is compared with `station_addr_i[47:40]` and frame byte 5 with `station_addr_i[7:0]`.
- R4: A frame whose destination address matches neither accepted address produces no pulse.
- R5: Frame bytes 6 to 11 (the source address) have no effect on the result.
- R6: Frame bytes 12..13 must be 0x88,0x08 (type) and bytes 14..15 must be 0x00,0x01 (opcode). Any other value in these bytes produces no pulse.
- R7: On a pulse, `pause_quanta_o` equals {byte 16, byte 17}, with byte 16 as the most significant byte. Any 16-bit value is accepted. The output keeps its last value until the next pulse.
- R8: A frame whose `rx_good_i` is 0 at the end-of-frame beat produces no pulse.
- R9: A frame with fewer than 18 bytes produces no pulse. Bytes after byte 17 are ignored.
- R10: `pause_det_o` rises in the cycle after the end-of-frame beat and stays high for exactly one clock.
- R11: A start-of-frame beat restarts parsing at byte 0, even in the middle of an unfinished frame. Cycles with `rx_valid_i` low carry no byte.
- R12: After reset, `pause_det_o` is 0 and `pause_quanta_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | A byte is present on `rx_data_i` |
| rx_data_i | input | 8 | Received byte |
| rx_sof_i | input | 1 | Current byte is the first byte of a frame |
| rx_eof_i | input | 1 | Current byte is the last byte of a frame |
| rx_good_i | input | 1 | Frame status, sampled on the end-of-frame beat |
| station_addr_i | input | 48 | Station's own address, most significant byte first on the wire |
| full_duplex_en_i | input | 1 | Full-duplex mode enable |
| flow_ctrl_en_i | input | 1 | Receive flow-control enable |
| pause_det_o | output | 1 | One-cycle pulse when a PAUSE frame is detected |
| pause_quanta_o | output | 16 | Pause time of the last detected frame |

## Verification
The assertions assume that `rx_sof_i`, `rx_eof_i` and `rx_good_i` mean something only when `rx_valid_i` is high. They also assume that `station_addr_i` and both enables stay steady for the length of a frame. The stimulus respects these assumptions: it changes the enables and the station address only between frames, and it drives the markers low on idle cycles. Idle gaps are inserted at random inside frames, and one frame is abandoned without an end marker so the restart rule is exercised. Random frame lengths go from well below the minimum to well above it.

// File: rtl/pause_det_pkg.sv
package pause_det_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned DA_BYTES    = 6;
  localparam int unsigned HDR_OFS     = 12;  // type + opcode start
  localparam int unsigned HDR_BYTES   = 4;
  localparam int unsigned QNT_OFS     = 16;
  localparam int unsigned FRAME_BYTES = QNT_OFS + 2;
  localparam int unsigned IDX_W       = $clog2(FRAME_BYTES + 1);

  localparam logic [8*DA_BYTES-1:0]  CTRL_MC_DA  = 48'h0180_C200_0001;
  localparam logic [8*HDR_BYTES-1:0] CTRL_HDR    = 32'h8808_0001;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t pick_da_byte(logic [8*DA_BYTES-1:0] v, idx_t i);
    int unsigned sh;
    if (int'(i) >= DA_BYTES) return '0;
    sh = 8 * (DA_BYTES - 1 - int'(i));
    return byte_t'(v >> sh);
  endfunction

  function automatic byte_t pick_hdr_byte(idx_t i);
    int unsigned sh;
    if (int'(i) < HDR_OFS || int'(i) >= HDR_OFS + HDR_BYTES) return '0;
    sh = 8 * (HDR_OFS + HDR_BYTES - 1 - int'(i));
    return byte_t'(CTRL_HDR >> sh);
  endfunction
endpackage

// File: rtl/pause_byte_pos.sv
module pause_byte_pos
  import pause_det_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic beat_i,
  input  logic sof_i,
  input  logic eof_i,
  output idx_t idx_o,
  output logic take_o
);
  localparam idx_t SAT = idx_t'(FRAME_BYTES);

  idx_t cnt_q;
  logic in_frame_q;

  assign idx_o  = sof_i ? '0 : cnt_q;
  assign take_o = beat_i && (sof_i || in_frame_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
    end else if (take_o) begin
      cnt_q      <= (idx_o == SAT) ? SAT : idx_o + idx_t'(1);
      in_frame_q <= !eof_i;
    end
  end

  AST_POS_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SAT) else $error("byte position beyond saturation"); // R9
  AST_SOF_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && sof_i && !eof_i) |=> (cnt_q == idx_t'(1))) else $error("sof did not restart"); // R11
endmodule

// File: rtl/pause_field_match.sv
module pause_field_match
  import pause_det_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    take_i,
  input  logic                    sof_i,
  input  idx_t                    idx_i,
  input  byte_t                   byte_i,
  input  logic [8*DA_BYTES-1:0]   station_i,
  output logic                    hdr_ok_o
);
  logic mc_q, st_q, tp_q;
  logic mc_n, st_n, tp_n;
  logic in_da, in_hdr;

  assign in_da  = int'(idx_i) < DA_BYTES;
  assign in_hdr = int'(idx_i) >= HDR_OFS && int'(idx_i) < HDR_OFS + HDR_BYTES;

  always_comb begin
    mc_n = mc_q;
    st_n = st_q;
    tp_n = tp_q;
    if (take_i) begin
      if (sof_i) begin
        mc_n = 1'b1;
        st_n = 1'b1;
        tp_n = 1'b1;
      end
      if (in_da) begin
        mc_n = mc_n && (byte_i == pick_da_byte(CTRL_MC_DA, idx_i));
        st_n = st_n && (byte_i == pick_da_byte(station_i, idx_i));
      end
      if (in_hdr) tp_n = tp_n && (byte_i == pick_hdr_byte(idx_i));
    end
  end

  assign hdr_ok_o = (mc_n || st_n) && tp_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc_q <= 1'b0;
      st_q <= 1'b0;
      tp_q <= 1'b0;
    end else begin
      mc_q <= mc_n;
      st_q <= st_n;
      tp_q <= tp_n;
    end
  end

  AST_MC_STICKY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mc_q && !(take_i && sof_i)) |=> !mc_q) else $error("mc match recovered"); // R4
  AST_TYPE_STICKY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tp_q && !(take_i && sof_i)) |=> !tp_q) else $error("type match recovered"); // R6
endmodule

// File: rtl/pause_quanta_cap.sv
module pause_quanta_cap
  import pause_det_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        take_i,
  input  idx_t        idx_i,
  input  byte_t       byte_i,
  output logic [15:0] quanta_next_o
);
  logic [15:0] sh_q;
  logic        grab;

  assign grab          = take_i && (int'(idx_i) == QNT_OFS || int'(idx_i) == QNT_OFS + 1);
  assign quanta_next_o = grab ? {sh_q[7:0], byte_i} : sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= quanta_next_o;
  end
endmodule

// File: rtl/pause_frame_detector.sv
module pause_frame_detector
  import pause_det_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_sof_i,
  input  logic        rx_eof_i,
  input  logic        rx_good_i,
  input  logic [47:0] station_addr_i,
  input  logic        full_duplex_en_i,
  input  logic        flow_ctrl_en_i,
  output logic        pause_det_o,
  output logic [15:0] pause_quanta_o
);
  idx_t        idx;
  logic        take;
  logic        hdr_ok;
  logic [15:0] quanta_next;
  logic        fire;
  logic        det_q;
  logic [15:0] quanta_q;

  pause_byte_pos u_pos (
    .clk_i (clk_i), .rst_ni (rst_ni), .beat_i (rx_valid_i),
    .sof_i (rx_sof_i), .eof_i (rx_eof_i), .idx_o (idx), .take_o (take)
  );

  pause_field_match u_match (
    .clk_i (clk_i), .rst_ni (rst_ni), .take_i (take), .sof_i (rx_sof_i),
    .idx_i (idx), .byte_i (rx_data_i), .station_i (station_addr_i), .hdr_ok_o (hdr_ok)
  );

  pause_quanta_cap u_qnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .take_i (take), .idx_i (idx),
    .byte_i (rx_data_i), .quanta_next_o (quanta_next)
  );

  assign fire = take && rx_eof_i && rx_good_i && full_duplex_en_i && flow_ctrl_en_i
             && hdr_ok && (int'(idx) >= FRAME_BYTES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q    <= 1'b0;
      quanta_q <= '0;
    end else begin
      det_q <= fire;
      if (fire) quanta_q <= quanta_next;
    end
  end

  assign pause_det_o    = det_q;
  assign pause_quanta_o = quanta_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_det_o |=> !pause_det_o) else $error("pulse too long"); // R10
  AST_PULSE_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_det_o |-> $past(rx_valid_i && rx_eof_i)) else $error("pulse without eof"); // R10
  AST_PULSE_NEEDS_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_det_o |-> $past(rx_good_i)) else $error("pulse on bad frame"); // R8
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_det_o |-> $past(full_duplex_en_i && flow_ctrl_en_i)) else $error("pulse while disabled"); // R1
  AST_QUANTA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_det_o |-> $stable(pause_quanta_o)) else $error("quanta changed without pulse"); // R7
endmodule

// File: tb/pause_frame_detector_tb_top.sv
`timescale 1ns/1ps
module pause_frame_detector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
  logic [47:0] station = 48'h02AB_CD12_3456;
  logic        fd_en = 1'b1, fc_en = 1'b1;
  logic        det;
  logic [15:0] quanta;

  int checks = 0, fails = 0;
  logic [7:0]  frm [0:79];
  int          flen;
  logic [15:0] last_q = '0;

  always #2.5 clk = ~clk;

  pause_frame_detector dut_i (
    .clk_i (clk), .rst_ni (rst_n), .rx_valid_i (rx_valid), .rx_data_i (rx_data),
    .rx_sof_i (rx_sof), .rx_eof_i (rx_eof), .rx_good_i (rx_good),
    .station_addr_i (station), .full_duplex_en_i (fd_en), .flow_ctrl_en_i (fc_en),
    .pause_det_o (det), .pause_quanta_o (quanta)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_det(input bit good);
    bit mc = 1, st = 1;
    if (flen < 18 || !good || !fd_en || !fc_en) return 0;
    for (int i = 0; i < 6; i++) begin
      if (frm[i] != 8'(48'h0180_C200_0001 >> (8*(5-i)))) mc = 0;
      if (frm[i] != 8'(station >> (8*(5-i)))) st = 0;
    end
    if (!(mc || st)) return 0;
    return {frm[12], frm[13], frm[14], frm[15]} == 32'h8808_0001;
  endfunction

  // kind: 0 multicast, 1 station, 2 wrong DA
  task automatic build(input int kind, input bit hdr_ok);
    for (int i = 0; i < 80; i++) frm[i] = 8'($urandom);
    for (int i = 0; i < 6; i++)
      frm[i] = (kind == 1) ? 8'(station >> (8*(5-i))) : 8'(48'h0180_C200_0001 >> (8*(5-i)));
    if (kind == 2) frm[$urandom_range(0, 5)] ^= 8'(1 << $urandom_range(0, 7));
    {frm[12], frm[13], frm[14], frm[15]} = 32'h8808_0001;
    if (!hdr_ok) frm[12 + $urandom_range(0, 3)] ^= 8'(1 << $urandom_range(0, 7));
  endtask

  task automatic drive(input int n, input bit with_eof, input bit good, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom_range(0, 3) == 0)) begin
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 8'($urandom);
      end
      @(negedge clk);
      rx_valid = 1; rx_data = frm[i];
      rx_sof = (i == 0); rx_eof = with_eof && (i == n - 1);
      rx_good = rx_eof ? good : 1'b0;
    end
  endtask

  task automatic run_frame(input string req, input bit good, input bit gaps);
    bit e;
    e = exp_det(good);
    drive(flen, 1'b1, good, gaps);
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0;
    chk(det == e, {req, " pulse"}, det, e);
    if (e) last_q = {frm[16], frm[17]};
    chk(quanta == last_q, "R7 quanta", quanta, last_q);
    @(negedge clk);
    chk(det == 0, "R10 single cycle", det, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(det == 0, "R12 det reset", det, 0);
    chk(quanta == 0, "R12 quanta reset", quanta, 0);
    rst_n = 1;
    @(negedge clk);

    build(0, 1); flen = 18; frm[16] = 8'hFF; frm[17] = 8'hFF; run_frame("R2", 1, 0);
    build(1, 1); flen = 60; frm[16] = 8'h00; frm[17] = 8'h00; run_frame("R3", 1, 0);
    build(1, 1); flen = 64; for (int i = 6; i < 12; i++) frm[i] = 8'hA5; run_frame("R5", 1, 1);
    build(2, 1); flen = 60; run_frame("R4", 1, 0);
    build(0, 0); flen = 60; run_frame("R6", 1, 0);
    build(0, 1); flen = 17; run_frame("R9 short", 1, 0);
    build(0, 1); flen = 60; run_frame("R8", 0, 0);
    fd_en = 0; build(0, 1); flen = 60; run_frame("R1 fd", 1, 0);
    fd_en = 1; fc_en = 0; build(0, 1); flen = 60; run_frame("R1 fc", 1, 0);
    fc_en = 1;
    // abandoned frame then restart
    build(2, 0); drive(10, 1'b0, 1'b0, 1'b0);
    build(0, 1); flen = 60; frm[16] = 8'h12; frm[17] = 8'h34; run_frame("R11", 1, 1);

    for (int k = 0; k < 80; k++) begin
      int kind;
      bit hdr, good;
      kind = $urandom_range(0, 2);
      hdr  = ($urandom_range(0, 3) != 0);
      good = ($urandom_range(0, 4) != 0);
      if ($urandom_range(0, 7) == 0) fd_en = 0;
      if ($urandom_range(0, 7) == 0) fc_en = 0;
      if ($urandom_range(0, 9) == 0) station = {$urandom, 16'($urandom)};
      build(kind, hdr);
      flen = $urandom_range(12, 80);
      run_frame("R9 rand", good, $urandom_range(0, 1) == 1);
      fd_en = 1; fc_en = 1;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule